// File: doc/BRIEF.md
# Update-Broadcast Snooping Cache Controller

This block is a small direct-mapped private cache with a coherence controller that keeps copies consistent by pushing written words to the other caches rather than killing their copies. Every resident line carries one of four coherence states, formed from two properties. The first is whether this cache owns the line, which means it must write the line back and must supply it to others. The second is whether other caches may hold it. An empty marker is used only for lines that were never filled or that were just written back. It plays no part in coherence.

The processor side issues one request at a time and holds it until `cpu_ready` is high. Bus transactions are assumed granted in the cycle they are presented, because arbitration lies outside the block. A fill takes its line from `fill_line` and its sharing status from `shared_in` in that same cycle. The snoop side presents the other caches' read misses and update broadcasts. The block answers in the same cycle on `snp_shared`, `snp_supply` and `snp_line`.

A miss completes in steps, one cycle each. An owned victim is first written back and its slot emptied. The line is then fetched. The request then completes as a hit in the following cycle.

Top module: `upd_snoop_cache`

## Requirements
- R1: After reset every line is empty. A snoop of any address leaves `snp_shared` and `snp_supply` low, and any processor access is a miss that presents a read (bus_cmd 1) with `cpu_ready` low.
- R2: A miss whose slot holds no owned line presents bus_cmd 1 with the line base address (offset bits zero) and loads `fill_line`. The line enters the unowned-exclusive state if `shared_in` is low, and the unowned-shared state if it is high.
- R3: A write hit on an unowned-exclusive or owned-exclusive line completes with `cpu_ready` high and bus_cmd 0, and leaves the line owned-exclusive.
- R4: A write hit on an unowned-shared or owned-shared line completes at once and presents an update broadcast (bus_cmd 2) with the full word address on `bus_addr` and the word on `bus_wdata`. The writer becomes owned-shared if `shared_in` is high and owned-exclusive if it is low.
- R5: A snooped update (snp_cmd 2) that matches a resident line overwrites the addressed word, leaves the line unowned-shared and raises `snp_shared`. A snooped update that matches no line changes nothing and leaves `snp_shared` low.
- R6: A snooped read (snp_cmd 1) that matches an owned line raises `snp_supply` and `snp_shared`, drives the whole line on `snp_line` (word 0 in the low bits), and leaves the line owned-shared. A match on an unowned line raises only `snp_shared` and leaves the line unowned-shared.
- R7: A miss whose slot holds an owned line first presents a write-back (bus_cmd 3) with the victim's line base address and its whole line on `bus_line`, with `cpu_ready` low. It then performs the fill of R2. An unowned victim is dropped without a write-back.
- R8: When a snoop and a processor request address the same slot in one cycle, the snoop is served, `cpu_ready` stays low and the bus stays idle. A snoop on a different slot does not delay the processor.
- R9: A read hit returns the addressed word on `cpu_rdata` with `cpu_ready` high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | Request is a write |
| cpu_addr | input | AW | Word address of the request |
| cpu_wdata | input | DW | Write word |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Read word |
| bus_cmd | output | 2 | 0 idle, 1 read, 2 update, 3 write-back |
| bus_addr | output | AW | Bus transaction address |
| bus_wdata | output | DW | Word for an update broadcast |
| bus_line | output | DW*WORDS | Line for a write-back |
| fill_line | input | DW*WORDS | Line returned for a read |
| shared_in | input | 1 | Another cache holds the line |
| snp_cmd | input | 2 | 0 none, 1 read, 2 update |
| snp_addr | input | AW | Snooped word address |
| snp_wdata | input | DW | Snooped update word |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies the snooped line |
| snp_line | output | DW*WORDS | Supplied line |

## Verification
The assertions assume that a processor request stays unchanged until `cpu_ready` rises. They also assume that the bus grants each presented transaction in its own cycle, so that a write-back is always followed by the fill for the same held request. The stimulus keeps the processor address fixed across every miss sequence. It changes the address only after a completed hit or on an idle cycle, and it drives `shared_in` and the fill data as the other caches and memory would in the cycle of the transaction.

// File: rtl/upd_snoop_cache.sv
module upd_snoop_cache #(
  parameter int DW    = 16,
  parameter int WORDS = 4,
  parameter int LINES = 4,
  parameter int AW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_valid,
  input  logic                cpu_write,
  input  logic [AW-1:0]       cpu_addr,
  input  logic [DW-1:0]       cpu_wdata,
  output logic                cpu_ready,
  output logic [DW-1:0]       cpu_rdata,
  output logic [1:0]          bus_cmd,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_wdata,
  output logic [DW*WORDS-1:0] bus_line,
  input  logic [DW*WORDS-1:0] fill_line,
  input  logic                shared_in,
  input  logic [1:0]          snp_cmd,
  input  logic [AW-1:0]       snp_addr,
  input  logic [DW-1:0]       snp_wdata,
  output logic                snp_shared,
  output logic                snp_supply,
  output logic [DW*WORDS-1:0] snp_line
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = AW - OFF_W - IDX_W;
  localparam int LW    = DW * WORDS;

  localparam logic [1:0] BC_IDLE = 2'd0, BC_READ = 2'd1, BC_UPD = 2'd2, BC_WB = 2'd3;
  localparam logic [1:0] SN_READ = 2'd1, SN_UPD = 2'd2;

  typedef enum logic [2:0] {LS_EMPTY, LS_UE, LS_US, LS_OE, LS_OS} lstate_t;

  lstate_t          st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LW-1:0]    dat_q [LINES];

  logic [TAG_W-1:0] c_tag, s_tag;
  logic [IDX_W-1:0] c_idx, s_idx;
  logic [OFF_W-1:0] c_off, s_off;

  assign {c_tag, c_idx, c_off} = cpu_addr;
  assign {s_tag, s_idx, s_off} = snp_addr;

  lstate_t c_st, s_st;
  assign c_st = st_q[c_idx];
  assign s_st = st_q[s_idx];

  logic c_hit, c_owned, s_hit, s_owned, conflict, c_go;
  logic evict_wb, do_fill, wr_upd;

  assign c_hit    = (c_st != LS_EMPTY) && (tag_q[c_idx] == c_tag);
  assign c_owned  = (c_st == LS_OE) || (c_st == LS_OS);
  assign s_hit    = (snp_cmd != 2'd0) && (s_st != LS_EMPTY) && (tag_q[s_idx] == s_tag);
  assign s_owned  = (s_st == LS_OE) || (s_st == LS_OS);
  assign conflict = cpu_valid && (snp_cmd != 2'd0) && (s_idx == c_idx);
  assign c_go     = cpu_valid && !conflict;

  assign evict_wb = c_go && !c_hit && c_owned;
  assign do_fill  = c_go && !c_hit && !c_owned;
  assign wr_upd   = c_go && c_hit && cpu_write && ((c_st == LS_US) || (c_st == LS_OS));

  assign cpu_ready = c_go && c_hit;
  assign cpu_rdata = dat_q[c_idx][c_off*DW +: DW];

  assign bus_cmd   = evict_wb ? BC_WB : do_fill ? BC_READ : wr_upd ? BC_UPD : BC_IDLE;
  assign bus_addr  = evict_wb ? {tag_q[c_idx], c_idx, {OFF_W{1'b0}}}
                   : do_fill  ? {c_tag, c_idx, {OFF_W{1'b0}}}
                   : cpu_addr;
  assign bus_wdata = cpu_wdata;
  assign bus_line  = dat_q[c_idx];

  assign snp_shared = s_hit;
  assign snp_supply = s_hit && (snp_cmd == SN_READ) && s_owned;
  assign snp_line   = dat_q[s_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LS_EMPTY;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      if (s_hit) begin
        if (snp_cmd == SN_UPD) begin
          dat_q[s_idx][s_off*DW +: DW] <= snp_wdata;
          st_q[s_idx] <= LS_US;
        end else if (snp_cmd == SN_READ) begin
          st_q[s_idx] <= s_owned ? LS_OS : LS_US;
        end
      end
      if (evict_wb) begin
        st_q[c_idx] <= LS_EMPTY;
      end else if (do_fill) begin
        tag_q[c_idx] <= c_tag;
        dat_q[c_idx] <= fill_line;
        st_q[c_idx]  <= shared_in ? LS_US : LS_UE;
      end else if (c_go && cpu_write) begin
        dat_q[c_idx][c_off*DW +: DW] <= cpu_wdata;
        if ((c_st == LS_UE) || (c_st == LS_OE))
          st_q[c_idx] <= LS_OE;
        else
          st_q[c_idx] <= shared_in ? LS_OS : LS_OE;
      end
    end
  end

  p_fill_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == BC_READ) |-> !cpu_ready);

  p_update_completes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == BC_UPD) |-> (cpu_ready && cpu_write));

  p_supply_needs_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_shared && snp_cmd == SN_READ));

  p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == BC_WB) |=> (!cpu_valid || conflict || bus_cmd == BC_READ));

  p_snoop_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (!cpu_ready && bus_cmd == BC_IDLE));

  p_wb_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == BC_WB) |-> !cpu_ready);
endmodule

// File: tb/upd_snoop_cache_tb_top.sv
`timescale 1ns/1ps
module upd_snoop_cache_tb_top;
  localparam int DW = 16, WORDS = 4, LINES = 4, AW = 8, LW = DW*WORDS;
  localparam int NV = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 0, cpu_write = 0, shared_in = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, snp_wdata = '0;
  logic [1:0] snp_cmd = '0;
  logic cpu_ready, snp_shared, snp_supply;
  logic [DW-1:0] cpu_rdata, bus_wdata;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [LW-1:0] bus_line, fill_line, snp_line;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int w = 0; w < WORDS; w++)
      fill_line[w*DW +: DW] = {bus_addr, 6'd0, w[1:0]};

  upd_snoop_cache #(.DW(DW), .WORDS(WORDS), .LINES(LINES), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_line(bus_line), .fill_line(fill_line),
    .shared_in(shared_in), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_wdata(snp_wdata), .snp_shared(snp_shared), .snp_supply(snp_supply),
    .snp_line(snp_line));

  typedef struct packed {
    logic cv; logic cw; logic [7:0] ca; logic [15:0] cd; logic sh;
    logic [1:0] sc; logic [7:0] sa; logic [15:0] sd;
    logic rdy; logic [1:0] cmd; logic [7:0] ba; logic [15:0] bw;
    logic chk; logic [15:0] rd; logic shr; logic sup;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1,0,8'h10,16'h0,0, 0,8'h00,16'h0, 0,1,8'h10,16'h0, 0,16'h0,0,0},    // R1 R2 miss, fill UE
    '{1,0,8'h12,16'h0,0, 0,8'h00,16'h0, 1,0,8'h00,16'h0, 1,16'h1002,0,0}, // R9 read hit
    '{1,1,8'h11,16'hAAAA,0, 0,8'h00,16'h0, 1,0,8'h00,16'h0, 0,16'h0,0,0}, // R3 UE write silent
    '{1,0,8'h11,16'h0,0, 0,8'h00,16'h0, 1,0,8'h00,16'h0, 1,16'hAAAA,0,0}, // R3 data kept
    '{1,1,8'h13,16'hBBBB,0, 0,8'h00,16'h0, 1,0,8'h00,16'h0, 0,16'h0,0,0}, // R3 OE write silent
    '{0,0,8'h00,16'h0,0, 1,8'h10,16'h0, 0,0,8'h00,16'h0, 0,16'h0,1,1},    // R6 owner supplies
    '{1,1,8'h10,16'hCCCC,1, 0,8'h00,16'h0, 1,2,8'h10,16'hCCCC, 0,16'h0,0,0}, // R4 update, stays OS
    '{1,1,8'h10,16'hDDDD,0, 0,8'h00,16'h0, 1,2,8'h10,16'hDDDD, 0,16'h0,0,0}, // R4 update, no sharer -> OE
    '{1,1,8'h10,16'hEEEE,1, 0,8'h00,16'h0, 1,0,8'h00,16'h0, 0,16'h0,0,0}, // R4 now OE: silent
    '{1,0,8'h50,16'h0,0, 0,8'h00,16'h0, 0,3,8'h10,16'h0, 0,16'h0,0,0},    // R7 owned victim write-back
    '{1,0,8'h50,16'h0,1, 0,8'h00,16'h0, 0,1,8'h50,16'h0, 0,16'h0,0,0},    // R7 R2 fill, shared -> US
    '{1,0,8'h51,16'h0,0, 0,8'h00,16'h0, 1,0,8'h00,16'h0, 1,16'h5001,0,0}, // R9
    '{1,1,8'h52,16'h1234,1, 0,8'h00,16'h0, 1,2,8'h52,16'h1234, 0,16'h0,0,0}, // R2 R4 US write broadcasts
    '{0,0,8'h00,16'h0,0, 2,8'h53,16'h7777, 0,0,8'h00,16'h0, 0,16'h0,1,0}, // R5 snooped update hit
    '{1,0,8'h53,16'h0,0, 0,8'h00,16'h0, 1,0,8'h00,16'h0, 1,16'h7777,0,0}, // R5 word replaced
    '{0,0,8'h00,16'h0,0, 2,8'h93,16'h1111, 0,0,8'h00,16'h0, 0,16'h0,0,0}, // R5 non-matching ignored
    '{1,0,8'h53,16'h0,0, 0,8'h00,16'h0, 1,0,8'h00,16'h0, 1,16'h7777,0,0}, // R5 data unchanged
    '{1,0,8'h90,16'h0,0, 0,8'h00,16'h0, 0,1,8'h90,16'h0, 0,16'h0,0,0},    // R5 R7 US victim dropped
    '{0,0,8'h00,16'h0,0, 1,8'h92,16'h0, 0,0,8'h00,16'h0, 0,16'h0,1,0},    // R6 unowned: no supply
    '{1,1,8'h90,16'h4444,0, 0,8'h00,16'h0, 1,2,8'h90,16'h4444, 0,16'h0,0,0}, // R6 became US
    '{1,0,8'h91,16'h0,0, 1,8'h90,16'h0, 0,0,8'h00,16'h0, 0,16'h0,1,1},    // R8 same slot stall
    '{1,0,8'h91,16'h0,0, 0,8'h00,16'h0, 1,0,8'h00,16'h0, 1,16'h9001,0,0}, // R8 retry hits
    '{1,0,8'h24,16'h0,0, 1,8'h90,16'h0, 0,1,8'h24,16'h0, 0,16'h0,1,1},    // R8 other slot proceeds
    '{1,0,8'hD0,16'h0,0, 0,8'h00,16'h0, 0,3,8'h90,16'h0, 0,16'h0,0,0}     // R6 R7 OS victim written back
  };

  task automatic chk(input string req, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      cpu_valid = VEC[v].cv; cpu_write = VEC[v].cw; cpu_addr = VEC[v].ca;
      cpu_wdata = VEC[v].cd; shared_in = VEC[v].sh; snp_cmd = VEC[v].sc;
      snp_addr = VEC[v].sa; snp_wdata = VEC[v].sd;
      #1;
      chk($sformatf("vec%0d", v), "cpu_ready", LW'(cpu_ready), LW'(VEC[v].rdy));
      chk($sformatf("vec%0d", v), "bus_cmd", LW'(bus_cmd), LW'(VEC[v].cmd));
      if (VEC[v].cmd != 2'd0)
        chk($sformatf("vec%0d", v), "bus_addr", LW'(bus_addr), LW'(VEC[v].ba));
      if (VEC[v].cmd == 2'd2)
        chk($sformatf("vec%0d R4", v), "bus_wdata", LW'(bus_wdata), LW'(VEC[v].bw));
      if (VEC[v].chk)
        chk($sformatf("vec%0d R9", v), "cpu_rdata", LW'(cpu_rdata), LW'(VEC[v].rd));
      chk($sformatf("vec%0d", v), "snp_shared", LW'(snp_shared), LW'(VEC[v].shr));
      chk($sformatf("vec%0d", v), "snp_supply", LW'(snp_supply), LW'(VEC[v].sup));
      if (v == 5)
        chk("R6", "snp_line", snp_line, {16'hBBBB, 16'h1002, 16'hAAAA, 16'h1000});
      if (v == 9)
        chk("R7", "bus_line", bus_line, {16'hBBBB, 16'h1002, 16'hAAAA, 16'hEEEE});
    end

    @(negedge clk);
    rst_n = 1'b0; cpu_valid = 0; snp_cmd = 0; shared_in = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    snp_cmd = 2'd1; snp_addr = 8'h90;
    #1;
    chk("R1", "snp_shared after reset", LW'(snp_shared), '0);
    chk("R1", "snp_supply after reset", LW'(snp_supply), '0);
    @(negedge clk);
    snp_cmd = 2'd0; cpu_valid = 1; cpu_write = 0; cpu_addr = 8'h24;
    #1;
    chk("R1", "cpu_ready after reset", LW'(cpu_ready), '0);
    chk("R1", "bus_cmd after reset", LW'(bus_cmd), LW'(2'd1));
    chk("R1", "bus_addr after reset", LW'(bus_addr), LW'(8'h24));
    @(negedge clk);
    cpu_valid = 0;
    finish_run();
  end
endmodule